// File: doc/BRIEF.md
# Parallel-Compute ALU with Result Selector and Condition Flags

This block is a small datapath slice. It holds a file of four general-purpose registers. Two read ports pick the operands `a` and `b`. Four operation circuits work on the two operands at the same time: add, subtract, an equality mask and a bitwise AND. A 2-bit selector drives a multiplexer that passes exactly one of the four results to the `result` output. The output path is purely combinational, so `result` follows any change of operands or selector within the same cycle.

Two independent strobes act on the rising clock edge.

- The write-back enable stores the selected result into the register named by the destination field. A separate load path can put an external value into that register instead, and it has priority over the result.
- The compare strobe compares the two operands as signed values. It records the outcome in a three-flag condition register that holds exactly one of greater-than, equal or less-than. The flags keep their value until the next compare.

Top module: `pallu_top`

## Requirements
- R1: After reset every register reads zero and the condition flags `ccr` are 3'b000.
- R2: With `op_sel` = 2'b00, `result` equals (a + b) modulo 2^W in the same cycle.
- R3: With `op_sel` = 2'b01, `result` equals (a − b) modulo 2^W, wrapping on underflow.
- R4: With `op_sel` = 2'b10, `result` is all ones when a equals b and all zeros otherwise.
- R5: With `op_sel` = 2'b11, `result` is the bitwise AND of a and b.
- R6: On a clock edge with `wr_en` high and `load_en` low, the register addressed by `dst` takes the value `result` had before the edge. With `load_en` high, that register takes `load_data`, whatever the state of `wr_en`.
- R7: On a clock edge with `cmp_en` high, `ccr` becomes 3'b100 if a > b, 3'b010 if a = b, and 3'b001 if a < b, with a and b taken as two's-complement signed values. Bit 2 is greater-than, bit 1 is equal and bit 0 is less-than.
- R8: On an edge with `cmp_en` low, `ccr` keeps its value.
- R9: When `cmp_en` and `wr_en` are high in the same cycle and `dst` names an operand register, both the flags and the written value use the operand values from before the edge.
- R10: On an edge with `wr_en` and `load_en` both low, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | AW | Register index for operand a |
| src_b | input | AW | Register index for operand b |
| op_sel | input | 2 | Result selector: 00 add, 01 subtract, 10 equality mask, 11 AND |
| dst | input | AW | Register index for write-back or load |
| wr_en | input | 1 | Write the selected result into `dst` on the edge |
| load_en | input | 1 | Write `load_data` into `dst` on the edge, overriding `wr_en` |
| load_data | input | W | External value for the load path |
| cmp_en | input | 1 | Update the condition flags from a signed compare on the edge |
| result | output | W | Selected operation result (combinational) |
| ccr | output | 3 | Condition flags {gt, eq, lt} |

## Verification
The compare strobe and write-back can act on the same edge. The case that matters is when the destination register is also operand a, so the flags and the new register value both depend on operands that the edge itself replaces. The bench raises `cmp_en` and `wr_en` together with `dst` equal to `src_a` for every operand pair of a 4-bit build, and it rotates the selected operation. After the edge it checks the flags against a signed compare of the old operands. It then reads the destination back through the AND of that register with itself and checks it against the chosen operation on the old operands.

// File: rtl/pallu_pkg.sv
package pallu_pkg;

    typedef enum logic [1:0] {
        SEL_ADD = 2'b00,
        SEL_SUB = 2'b01,
        SEL_EQ  = 2'b10,
        SEL_AND = 2'b11
    } op_sel_e;

    localparam int          CC_W    = 3;
    localparam logic [2:0]  CC_NONE = 3'b000;
    localparam logic [2:0]  CC_GT   = 3'b100;
    localparam logic [2:0]  CC_EQ   = 3'b010;
    localparam logic [2:0]  CC_LT   = 3'b001;

endpackage

// File: rtl/pallu_regfile.sv
module pallu_regfile #(
    parameter  int W    = 8,
    parameter  int NREG = 4,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data
);

    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && (wr_idx == AW'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_a = regs[rd_a_idx];
        rd_b = regs[rd_b_idx];
    end

endmodule

// File: rtl/pallu_opbank.sv
module pallu_opbank
    import pallu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [1:0]   sel,
    output logic [W-1:0] res
);

    logic [W-1:0] sum_r;
    logic [W-1:0] diff_r;
    logic [W-1:0] eqm_r;
    logic [W-1:0] and_r;

    // every circuit evaluates continuously; the selector only steers
    always_comb begin
        sum_r  = opa + opb;
        diff_r = opa - opb;
        eqm_r  = (opa == opb) ? '1 : '0;
        and_r  = opa & opb;
    end

    always_comb begin
        unique case (op_sel_e'(sel))
            SEL_ADD: res = sum_r;
            SEL_SUB: res = diff_r;
            SEL_EQ:  res = eqm_r;
            SEL_AND: res = and_r;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/pallu_ccr.sv
module pallu_ccr
    import pallu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmp_en,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    output logic [CC_W-1:0] flags
);

    logic [CC_W-1:0] next_flags;

    always_comb begin
        if ($signed(opa) > $signed(opb)) begin
            next_flags = CC_GT;
        end else if (opa == opb) begin
            next_flags = CC_EQ;
        end else begin
            next_flags = CC_LT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= CC_NONE;
        end else if (cmp_en) begin
            flags <= next_flags;
        end
    end

endmodule

// File: rtl/pallu_top.sv
module pallu_top
    import pallu_pkg::*;
#(
    parameter  int W    = 8,
    parameter  int NREG = 4,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] src_b,
    input  logic [1:0]    op_sel,
    input  logic [AW-1:0] dst,
    input  logic          wr_en,
    input  logic          load_en,
    input  logic [W-1:0]  load_data,
    input  logic          cmp_en,
    output logic [W-1:0]  result,
    output logic [2:0]    ccr
);

    logic [W-1:0] rd_a;
    logic [W-1:0] rd_b;
    logic [W-1:0] wdata;
    logic         we;

    always_comb begin
        we    = wr_en | load_en;
        wdata = load_en ? load_data : result;
    end

    pallu_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (src_a),
        .rd_b_idx (src_b),
        .rd_a     (rd_a),
        .rd_b     (rd_b),
        .we       (we),
        .wr_idx   (dst),
        .wr_data  (wdata)
    );

    pallu_opbank #(.W(W)) u_ops (
        .opa (rd_a),
        .opb (rd_b),
        .sel (op_sel),
        .res (result)
    );

    pallu_ccr #(.W(W)) u_cc (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_en (cmp_en),
        .opa    (rd_a),
        .opb    (rd_b),
        .flags  (ccr)
    );

endmodule

// File: rtl/pallu_checker.sv
module pallu_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmp_en,
    input logic [1:0]   op_sel,
    input logic [W-1:0] rd_a,
    input logic [W-1:0] rd_b,
    input logic [W-1:0] result,
    input logic [2:0]   ccr
);

    a_r8_ccr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(ccr));

    a_r7_ccr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> $onehot(ccr));

    a_r7_ccr_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && (rd_a == rd_b)) |=> (ccr == 3'b010));

    a_r7_ccr_greater: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && ($signed(rd_a) > $signed(rd_b))) |=> (ccr == 3'b100));

    a_r4_eq_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b10) |-> ((result == '0) || (result == '1)));

endmodule

bind pallu_top pallu_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmp_en (cmp_en),
    .op_sel (op_sel),
    .rd_a   (rd_a),
    .rd_b   (rd_b),
    .result (result),
    .ccr    (ccr)
);

// File: tb/pallu_top_bench.sv
module pallu_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BW         = 4;
    localparam int NV         = 1 << BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    src_a = '0;
    logic [1:0]    src_b = '0;
    logic [1:0]    op_sel = '0;
    logic [1:0]    dst = '0;
    logic          wr_en = 1'b0;
    logic          load_en = 1'b0;
    logic [BW-1:0] load_data = '0;
    logic          cmp_en = 1'b0;
    logic [BW-1:0] result;
    logic [2:0]    ccr;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pallu_top #(.W(BW), .NREG(4)) u_pallu_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a     (src_a),
        .src_b     (src_b),
        .op_sel    (op_sel),
        .dst       (dst),
        .wr_en     (wr_en),
        .load_en   (load_en),
        .load_data (load_data),
        .cmp_en    (cmp_en),
        .result    (result),
        .ccr       (ccr)
    );

    function automatic logic [BW-1:0] model_op(input int s, input int a, input int b);
        case (s)
            0:       return BW'((a + b) % NV);
            1:       return BW'((a - b + NV) % NV);
            2:       return (a == b) ? {BW{1'b1}} : {BW{1'b0}};
            default: return BW'(a) & BW'(b);
        endcase
    endfunction

    function automatic logic [2:0] model_cc(input int a, input int b);
        int sa = (a >= NV/2) ? a - NV : a;
        int sb = (b >= NV/2) ? b - NV : b;
        if (sa > sb) return 3'b100;
        if (sa == sb) return 3'b010;
        return 3'b001;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // one edge with the current controls, then drop the strobes at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        load_en = 1'b0;
        cmp_en  = 1'b0;
    endtask

    task automatic load_reg(input int r, input int v);
        dst = 2'(r); load_data = BW'(v); load_en = 1'b1;
        tick();
    endtask

    task automatic read_reg(input int r, output logic [BW-1:0] v);
        src_a = 2'(r); src_b = 2'(r); op_sel = 2'b11;
        #1 v = result;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [BW-1:0] rv;
        logic [2:0]    prev_cc;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents
        for (int r = 0; r < 4; r++) begin
            read_reg(r, rv);
            check("R1 register reset", 8'(rv), 8'h0);
        end
        check("R1 flags reset", 8'(ccr), 8'h0);
        prev_cc = 3'b000;

        for (int a = 0; a < NV; a++) begin
            for (int b = 0; b < NV; b++) begin
                load_reg(0, a);
                load_reg(1, b);
                // R8: loads without compare leave the flags alone
                check("R8 flags held", 8'(ccr), 8'(prev_cc));

                src_a = 2'd0; src_b = 2'd1;
                for (int s = 0; s < 4; s++) begin
                    op_sel = 2'(s);
                    #1;
                    case (s)
                        0: check("R2 add", 8'(result), 8'(model_op(s, a, b)));
                        1: check("R3 sub", 8'(result), 8'(model_op(s, a, b)));
                        2: check("R4 eq mask", 8'(result), 8'(model_op(s, a, b)));
                        default: check("R5 and", 8'(result), 8'(model_op(s, a, b)));
                    endcase
                end

                // R10: no enable, no change
                op_sel = 2'b00; dst = 2'd0;
                tick();
                read_reg(0, rv);
                check("R10 idle keeps reg", 8'(rv), 8'(a));

                // R9, R6, R7: compare and write-back into operand a on one edge
                begin
                    int s = (a + b) % 4;
                    src_a = 2'd0; src_b = 2'd1; op_sel = 2'(s);
                    dst = 2'd0; wr_en = 1'b1; cmp_en = 1'b1;
                    tick();
                    check("R7 R9 flags from old operands", 8'(ccr), 8'(model_cc(a, b)));
                    read_reg(0, rv);
                    check("R6 R9 write-back of old result", 8'(rv), 8'(model_op(s, a, b)));
                    read_reg(1, rv);
                    check("R6 other reg untouched", 8'(rv), 8'(b));
                end
                prev_cc = model_cc(a, b);
            end
        end

        // R6: load overrides write-back
        load_reg(2, 5);
        load_reg(3, 9);
        src_a = 2'd2; src_b = 2'd3; op_sel = 2'b00;
        dst = 2'd3; load_data = 4'hA; load_en = 1'b1; wr_en = 1'b1;
        tick();
        read_reg(3, rv);
        check("R6 load priority", 8'(rv), 8'hA);
        src_a = 2'd2; src_b = 2'd3; op_sel = 2'b00; dst = 2'd2; wr_en = 1'b1;
        tick();
        read_reg(2, rv);
        check("R6 write-back add", 8'(rv), 8'hF);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule